// File: doc/BRIEF.md
# Flash Flag Status Register

This block keeps the eight-bit flag status byte of a serial NOR flash controller. It watches the program/erase engine through command strobes and event pulses. It also tracks the engine's current operation in a small state machine. Fault events that arrive while a program or erase is running set sticky error flags. The suspend and ready flags follow the engine's live state, and one bit mirrors the current address width. Software reads the byte through a read strobe.

The error flags stay set until a clear-flags strobe arrives. While any error flag is set, a new program or erase command is refused. A refused command does not start. Instead it raises the error flag of its own kind and pulses a "command blocked" output for one cycle. Register-write cycles are tracked as busy time, but they never raise or report errors and are never refused.

The engine tracker has eight states. IDLE: nothing running. PROG: program running. PROG_HOLD: program suspend pending, which lasts SUSP_LAT cycles. PROG_PARKED: program suspended. ERASE, ERASE_HOLD and ERASE_PARKED are the same three states for an erase. REGWR: register write running. The transitions are as follows. IDLE goes to PROG, ERASE or REGWR when a command is accepted. PROG and ERASE go to their HOLD state on a suspend request. A HOLD state goes to its PARKED state when its counter expires. A PARKED state goes back to PROG or ERASE on a resume request. PROG, ERASE and both HOLD states return to IDLE on completion or on any fault. REGWR returns to IDLE on completion.

Top module: `flag_status_reg`

## Requirements
- R1: After reset, bits 6 to 1 read 0, bit 7 reads 1 (idle), and bit 0 equals `por_addr4`. Reset is synchronous and active low.
- R2: Bit 0 reads 1 for four-byte addressing and 0 for three-byte addressing. Out of reset it equals the value `addr4_mode` had one clock earlier.
- R3: Bit 7 (ready) reads 0 during PROG, PROG_HOLD, ERASE, ERASE_HOLD and REGWR. It reads 1 in IDLE, PROG_PARKED and ERASE_PARKED.
- R4: Bit 2 (program suspend) reads 1 from the cycle after `susp_req` in PROG. It stays 1 through the SUSP_LAT pending cycles and the suspended state. It returns to 0 the cycle after `resume_req`.
- R5: Bit 6 (erase suspend) behaves the same way for an erase.
- R6: During PROG or PROG_HOLD, `evt_fail` sets bit 4 and `evt_prot` sets bit 1. Either event, or `op_done`, ends the operation.
- R7: During ERASE or ERASE_HOLD, `evt_fail` or `evt_prot` sets bit 5 and ends the operation.
- R8: `evt_supply` during a running program or erase sets bit 3 and ends the operation.
- R9: Error bits 5, 4, 3 and 1 hold until `clr_flags`, which clears them at the next edge. A bit being set in the same cycle as the clear stays set.
- R10: Fault events during IDLE, REGWR or a suspended state change no flag.
- R11: In IDLE with any error bit set, `cmd_prog` or `cmd_erase` is refused. The engine stays idle, `cmd_blocked` pulses the next cycle, and bit 4 (program) or bit 5 (erase) is set. `cmd_regwr` is never refused.
- R12: `rd_stb` returns, one cycle later, the byte held at the strobe's edge on `rd_data`, with `rd_valid` high for that one cycle.
- R13: Commands are taken only in IDLE, with program above erase above register write. Outside IDLE, commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_addr4 | input | 1 | Address width loaded at reset |
| addr4_mode | input | 1 | Live four-byte address mode |
| cmd_prog | input | 1 | Program command strobe |
| cmd_erase | input | 1 | Erase command strobe |
| cmd_regwr | input | 1 | Register write command strobe |
| op_done | input | 1 | Engine completion pulse |
| evt_fail | input | 1 | Operation failure pulse |
| evt_prot | input | 1 | Protected region hit pulse |
| evt_supply | input | 1 | Invalid programming supply pulse |
| susp_req | input | 1 | Suspend request pulse |
| resume_req | input | 1 | Resume request pulse |
| clr_flags | input | 1 | Clear error flags strobe |
| rd_stb | input | 1 | Read status strobe |
| fsr_o | output | 8 | Live flag status byte |
| rd_data | output | 8 | Byte captured by the read strobe |
| rd_valid | output | 1 | Read data valid pulse |
| cmd_blocked | output | 1 | Refused command pulse |

## Verification
The bench covers several boundary cases, and each catches a specific wrong design:
- Clear and new fault in the same cycle: a design that lets the clear win would lose the fault.
- Clear together with a refused erase: a design that ignores the refusal would report no error.
- Faults while suspended or during a register write: a design that does not filter by engine state would raise flags there.
- Program command while an erase is parked: a design that accepts it would start a nested operation and drop the ready bit.
- A fault during the suspend-pending window: a design that missed it would leave the suspend bit stuck.
- Reset with errors set and the power-on address input high: this exposes a design that keeps stale errors or loads a fixed address width.

// File: rtl/ffsr_pkg.sv
package ffsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_PROG_HOLD,
        ST_PROG_PARKED,
        ST_ERASE,
        ST_ERASE_HOLD,
        ST_ERASE_PARKED,
        ST_REGWR
    } eng_state_e;

    localparam int FSR_W       = 8;
    localparam int B_READY     = 7;
    localparam int B_ESUSP     = 6;
    localparam int B_ERR_ERASE = 5;
    localparam int B_ERR_PROG  = 4;
    localparam int B_ERR_VOLT  = 3;
    localparam int B_PSUSP     = 2;
    localparam int B_ERR_PROT  = 1;
    localparam int B_ADDR4     = 0;

    localparam int NERR        = 4;
    localparam int IX_ERASE    = 0;
    localparam int IX_PROG     = 1;
    localparam int IX_VOLT     = 2;
    localparam int IX_PROT     = 3;

endpackage

// File: rtl/ffsr_engine_fsm.sv
module ffsr_engine_fsm
    import ffsr_pkg::*;
#(
    parameter int SUSP_LAT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_prog,
    input  logic       cmd_erase,
    input  logic       cmd_regwr,
    input  logic       op_done,
    input  logic       fault_any,
    input  logic       susp_req,
    input  logic       resume_req,
    input  logic       err_pending,
    output logic       in_prog,
    output logic       in_erase,
    output logic       blk_prog,
    output logic       blk_erase,
    output logic       ready,
    output logic       psusp,
    output logic       esusp
);

    localparam int CW = (SUSP_LAT > 1) ? $clog2(SUSP_LAT) : 1;
    localparam logic [CW-1:0] HOLD_LAST = CW'(SUSP_LAT - 1);

    eng_state_e state_q, state_d;
    logic [CW-1:0] hold_cnt_q, hold_cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            hold_cnt_q <= '0;
        end else begin
            state_q    <= state_d;
            hold_cnt_q <= hold_cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d    = state_q;
        hold_cnt_d = hold_cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_prog) begin
                    if (!err_pending) state_d = ST_PROG;
                end else if (cmd_erase) begin
                    if (!err_pending) state_d = ST_ERASE;
                end else if (cmd_regwr) begin
                    state_d = ST_REGWR;
                end
            end
            ST_PROG: begin
                if (fault_any || op_done) begin
                    state_d = ST_IDLE;
                end else if (susp_req) begin
                    state_d    = ST_PROG_HOLD;
                    hold_cnt_d = '0;
                end
            end
            ST_PROG_HOLD: begin
                if (fault_any || op_done) begin
                    state_d = ST_IDLE;
                end else if (hold_cnt_q == HOLD_LAST) begin
                    state_d = ST_PROG_PARKED;
                end else begin
                    hold_cnt_d = hold_cnt_q + 1'b1;
                end
            end
            ST_PROG_PARKED: begin
                if (resume_req) state_d = ST_PROG;
            end
            ST_ERASE: begin
                if (fault_any || op_done) begin
                    state_d = ST_IDLE;
                end else if (susp_req) begin
                    state_d    = ST_ERASE_HOLD;
                    hold_cnt_d = '0;
                end
            end
            ST_ERASE_HOLD: begin
                if (fault_any || op_done) begin
                    state_d = ST_IDLE;
                end else if (hold_cnt_q == HOLD_LAST) begin
                    state_d = ST_ERASE_PARKED;
                end else begin
                    hold_cnt_d = hold_cnt_q + 1'b1;
                end
            end
            ST_ERASE_PARKED: begin
                if (resume_req) state_d = ST_ERASE;
            end
            ST_REGWR: begin
                if (op_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_prog   = 1'b0;
        in_erase  = 1'b0;
        ready     = 1'b0;
        psusp     = 1'b0;
        esusp     = 1'b0;
        blk_prog  = 1'b0;
        blk_erase = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready     = 1'b1;
                blk_prog  = cmd_prog && err_pending;
                blk_erase = !cmd_prog && cmd_erase && err_pending;
            end
            ST_PROG:         in_prog = 1'b1;
            ST_PROG_HOLD: begin
                in_prog = 1'b1;
                psusp   = 1'b1;
            end
            ST_PROG_PARKED: begin
                ready = 1'b1;
                psusp = 1'b1;
            end
            ST_ERASE:        in_erase = 1'b1;
            ST_ERASE_HOLD: begin
                in_erase = 1'b1;
                esusp    = 1'b1;
            end
            ST_ERASE_PARKED: begin
                ready = 1'b1;
                esusp = 1'b1;
            end
            ST_REGWR:        ready = 1'b0;
            default:         ready = 1'b0;
        endcase
    end

    // R13
    parked_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG_PARKED && !resume_req) |=> (state_q == ST_PROG_PARKED));

    // R11
    refused_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && err_pending && (cmd_prog || cmd_erase)) |=> (state_q == ST_IDLE));

    // R6
    prog_fault_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_prog && fault_any) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/ffsr_sticky_errs.sv
module ffsr_sticky_errs
    import ffsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_prog,
    input  logic            in_erase,
    input  logic            evt_fail,
    input  logic            evt_prot,
    input  logic            evt_supply,
    input  logic            blk_prog,
    input  logic            blk_erase,
    input  logic            clr,
    output logic [NERR-1:0] err_q,
    output logic            err_pending,
    output logic            cmd_blocked
);

    logic [NERR-1:0] set_v;

    always_comb begin
        set_v           = '0;
        set_v[IX_ERASE] = (in_erase && (evt_fail || evt_prot)) || blk_erase;
        set_v[IX_PROG]  = (in_prog && evt_fail) || blk_prog;
        set_v[IX_VOLT]  = (in_prog || in_erase) && evt_supply;
        set_v[IX_PROT]  = in_prog && evt_prot;
    end

    for (genvar g = 0; g < NERR; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n)        err_q[g] <= 1'b0;
            else if (set_v[g]) err_q[g] <= 1'b1;
            else if (clr)      err_q[g] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cmd_blocked <= 1'b0;
        else        cmd_blocked <= blk_prog || blk_erase;
    end

    assign err_pending = |err_q;

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((err_q & $past(err_q)) == $past(err_q)));

    // R9
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !in_prog && !in_erase && !blk_prog && !blk_erase) |=> (err_q == '0));

    // R10
    quiet_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_prog && !in_erase && !blk_prog && !blk_erase && err_q == '0) |=> (err_q == '0));

    // R11
    blocked_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_blocked |-> err_pending);

endmodule

// File: rtl/ffsr_read_port.sv
module ffsr_read_port
    import ffsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_stb,
    input  logic [FSR_W-1:0] fsr_in,
    output logic [FSR_W-1:0] rd_data,
    output logic             rd_valid
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) rd_data <= fsr_in;
        end
    end

    // R12
    read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (rd_valid && rd_data == $past(fsr_in)));

endmodule

// File: rtl/flag_status_reg.sv
module flag_status_reg
    import ffsr_pkg::*;
#(
    parameter int SUSP_LAT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_addr4,
    input  logic       addr4_mode,
    input  logic       cmd_prog,
    input  logic       cmd_erase,
    input  logic       cmd_regwr,
    input  logic       op_done,
    input  logic       evt_fail,
    input  logic       evt_prot,
    input  logic       evt_supply,
    input  logic       susp_req,
    input  logic       resume_req,
    input  logic       clr_flags,
    input  logic       rd_stb,
    output logic [7:0] fsr_o,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    output logic       cmd_blocked
);

    logic in_prog, in_erase, blk_prog, blk_erase;
    logic ready, psusp, esusp, err_pending;
    logic [NERR-1:0] err_q;
    logic addr_q;

    ffsr_engine_fsm #(.SUSP_LAT(SUSP_LAT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_prog   (cmd_prog),
        .cmd_erase  (cmd_erase),
        .cmd_regwr  (cmd_regwr),
        .op_done    (op_done),
        .fault_any  (evt_fail || evt_prot || evt_supply),
        .susp_req   (susp_req),
        .resume_req (resume_req),
        .err_pending(err_pending),
        .in_prog    (in_prog),
        .in_erase   (in_erase),
        .blk_prog   (blk_prog),
        .blk_erase  (blk_erase),
        .ready      (ready),
        .psusp      (psusp),
        .esusp      (esusp)
    );

    ffsr_sticky_errs u_errs (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_prog    (in_prog),
        .in_erase   (in_erase),
        .evt_fail   (evt_fail),
        .evt_prot   (evt_prot),
        .evt_supply (evt_supply),
        .blk_prog   (blk_prog),
        .blk_erase  (blk_erase),
        .clr        (clr_flags),
        .err_q      (err_q),
        .err_pending(err_pending),
        .cmd_blocked(cmd_blocked)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= por_addr4;
        else        addr_q <= addr4_mode;
    end

    always_comb begin
        fsr_o              = '0;
        fsr_o[B_READY]     = ready;
        fsr_o[B_ESUSP]     = esusp;
        fsr_o[B_ERR_ERASE] = err_q[IX_ERASE];
        fsr_o[B_ERR_PROG]  = err_q[IX_PROG];
        fsr_o[B_ERR_VOLT]  = err_q[IX_VOLT];
        fsr_o[B_PSUSP]     = psusp;
        fsr_o[B_ERR_PROT]  = err_q[IX_PROT];
        fsr_o[B_ADDR4]     = addr_q;
    end

    ffsr_read_port u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .fsr_in  (fsr_o),
        .rd_data (rd_data),
        .rd_valid(rd_valid)
    );

    // R2
    addr_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fsr_o[B_ADDR4] == $past(addr4_mode)));

    // R4
    one_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fsr_o[B_PSUSP] && fsr_o[B_ESUSP]));

    // R3
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_prog || in_erase) |-> !fsr_o[B_READY]);

endmodule

// File: tb/tb_flag_status_reg.sv
module tb_flag_status_reg;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_addr4 = 1'b0, addr4_mode = 1'b0;
    logic cmd_prog = 1'b0, cmd_erase = 1'b0, cmd_regwr = 1'b0, op_done = 1'b0;
    logic evt_fail = 1'b0, evt_prot = 1'b0, evt_supply = 1'b0;
    logic susp_req = 1'b0, resume_req = 1'b0, clr_flags = 1'b0, rd_stb = 1'b0;
    logic [7:0] fsr_o, rd_data;
    logic rd_valid, cmd_blocked;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    flag_status_reg #(.SUSP_LAT(2)) dut (
        .clk(clk), .rst_n(rst_n), .por_addr4(por_addr4), .addr4_mode(addr4_mode),
        .cmd_prog(cmd_prog), .cmd_erase(cmd_erase), .cmd_regwr(cmd_regwr),
        .op_done(op_done), .evt_fail(evt_fail), .evt_prot(evt_prot),
        .evt_supply(evt_supply), .susp_req(susp_req), .resume_req(resume_req),
        .clr_flags(clr_flags), .rd_stb(rd_stb), .fsr_o(fsr_o), .rd_data(rd_data),
        .rd_valid(rd_valid), .cmd_blocked(cmd_blocked)
    );

    // {prog,erase,regwr,done,fail,prot,supply,susp,resume,clr,addr4, exp_blocked, exp_fsr}
    localparam int NV = 33;
    localparam logic [19:0] VEC [NV] = '{
        20'b0_0_0_0_0_0_0_0_0_0_0_0_1000_0000, //  0 R3 idle
        20'b0_0_0_0_0_0_0_0_0_0_1_0_1000_0001, //  1 R2 four-byte mode
        20'b1_0_0_0_0_0_0_0_0_0_1_0_0000_0001, //  2 R3 program busy
        20'b0_0_0_0_0_0_0_0_0_0_1_0_0000_0001, //  3
        20'b0_0_0_0_0_0_0_1_0_0_1_0_0000_0101, //  4 R4 suspend pending
        20'b0_0_0_0_0_0_0_0_0_0_1_0_0000_0101, //  5 R4 still pending
        20'b0_0_0_0_0_0_0_0_0_0_1_0_1000_0101, //  6 R4 parked
        20'b0_0_0_0_1_0_0_0_0_0_1_0_1000_0101, //  7 R10 fault while parked
        20'b0_0_0_0_0_0_0_0_1_0_1_0_0000_0001, //  8 R4 resume
        20'b0_0_0_1_0_0_0_0_0_0_1_0_1000_0001, //  9 R6 done
        20'b0_1_0_0_0_0_0_0_0_0_1_0_0000_0001, // 10 erase
        20'b0_0_0_0_0_0_1_0_0_0_1_0_1000_1001, // 11 R8 supply fault
        20'b1_0_0_0_0_0_0_0_0_0_1_1_1001_1001, // 12 R11 program refused
        20'b0_0_0_0_0_0_0_0_0_1_1_0_1000_0001, // 13 R9 clear
        20'b0_1_0_0_0_0_0_0_0_0_1_0_0000_0001, // 14 erase
        20'b0_0_0_0_0_0_0_1_0_0_1_0_0100_0001, // 15 R5 pending
        20'b0_0_0_0_0_0_0_0_0_0_1_0_0100_0001, // 16 R5
        20'b0_0_0_0_0_0_0_0_0_0_1_0_1100_0001, // 17 R5 parked
        20'b1_0_0_0_0_0_0_0_0_0_1_0_1100_0001, // 18 R13 program ignored
        20'b0_0_0_0_0_0_0_0_1_0_1_0_0000_0001, // 19 R5 resume
        20'b0_0_0_0_0_1_0_0_0_0_1_0_1010_0001, // 20 R7 erase protection
        20'b0_1_0_0_0_0_0_0_0_1_1_1_1010_0001, // 21 R9 R11 refusal beats clear
        20'b0_0_0_0_0_0_0_0_0_1_1_0_1000_0001, // 22 R9 clear
        20'b1_0_0_0_0_0_0_0_0_0_1_0_0000_0001, // 23 program
        20'b0_0_0_0_0_1_0_0_0_0_1_0_1000_0011, // 24 R6 protection
        20'b0_0_0_0_0_0_0_0_0_1_1_0_1000_0001, // 25 R9 clear
        20'b1_0_0_0_0_0_0_0_0_0_1_0_0000_0001, // 26 program
        20'b0_0_0_0_1_0_0_0_0_1_1_0_1001_0001, // 27 R9 fault beats clear
        20'b0_0_1_0_0_0_0_0_0_0_1_0_0001_0001, // 28 R11 regwr not refused
        20'b0_0_0_0_1_0_0_0_0_0_1_0_0001_0001, // 29 R10 fault in regwr
        20'b0_0_0_1_0_0_0_0_0_0_1_0_1001_0001, // 30 R3 regwr done
        20'b0_0_0_0_0_0_0_0_0_1_1_0_1000_0001, // 31 R9 clear
        20'b0_0_0_0_0_0_0_0_0_0_0_0_1000_0000  // 32 R2 three-byte mode
    };

    task automatic chk(input string what, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic drive(input logic [10:0] v);
        {cmd_prog, cmd_erase, cmd_regwr, op_done, evt_fail, evt_prot,
         evt_supply, susp_req, resume_req, clr_flags, addr4_mode} = v;
    endtask

    task automatic step_chk(input string what, input logic [10:0] v, input logic [7:0] exp);
        drive(v);
        @(negedge clk);
        chk(what, {cmd_blocked, fsr_o}, {1'b0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset byte", {cmd_blocked, fsr_o}, 9'h080);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][19:9]);
            @(negedge clk);
            chk($sformatf("vector %0d", i), {cmd_blocked, fsr_o}, VEC[i][8:0]);
        end
        drive('0);

        // R12 read strobe
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        chk("R12 read data", {rd_valid, rd_data}, 9'h180);
        @(negedge clk);
        chk("R12 valid drops", {8'h00, rd_valid}, 9'h000);

        // R6 fault inside suspend-pending window
        step_chk("R6 start", 11'b10000000000, 8'h00);
        step_chk("R4 pending", 11'b00000001000, 8'h04);
        step_chk("R6 fault in pending", 11'b00001000000, 8'h90);
        step_chk("R9 clear", 11'b00000000010, 8'h80);

        // R13 priority and busy ignore
        step_chk("R13 program wins", 11'b11000000000, 8'h00);
        step_chk("R13 program suspend bit", 11'b00000001000, 8'h04);
        step_chk("R13 erase ignored", 11'b01000000000, 8'h04);
        step_chk("R13 done in pending", 11'b00010000000, 8'h80);

        // R1 R2 reset with errors and power-on four-byte mode
        step_chk("R8 erase", 11'b01000000000, 8'h00);
        step_chk("R8 supply", 11'b00000010000, 8'h88);
        drive('0);
        por_addr4 = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears errors", {cmd_blocked, fsr_o}, 9'h081);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 tracks live mode", {cmd_blocked, fsr_o}, 9'h080);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule